// File: doc/BRIEF.md
# Port Power-Down Register Gate

This block sits between a simple register bus and the per-port register windows of a multi-port serial switch. Every port can be switched off to save power. While a port is off, the block hides and write-protects the register groups that describe live link state. The electrical-layer group and the port's clock-select register stay reachable, so the port can be set up and then woken. The block also drives, for each port, a power-up level and an I/O speed code that the link logic consumes.

Each port has a small power state machine with four states. PWR_BOOT is held during reset and lasts for the first cycle after release, when the strap pin is sampled. PWR_STRAP_DOWN means the port was held down by its pin. PWR_REG_DOWN means the port was powered down by a register write. PWR_UP means the port is running. The transitions are:

- BOOT_TO_STRAP: pin high at release.
- BOOT_TO_UP: pin low, or the port has no pin.
- WAKE_WRITE: any down state or BOOT to PWR_UP, on a clock-select write whose low nibble is not 0xC.
- SLEEP_WRITE: any state to PWR_REG_DOWN, on a clock-select write whose low nibble is 0xC.

Port 0 has no pin. Moving port 0 to another speed therefore takes a SLEEP_WRITE followed by a WAKE_WRITE that carries the new speed.

The address map gives each port a 16-word window at a stride of 16 words. The port number sits in the address bits just above the window offset. The offsets within a window are:

| Offset | Register |
|--------|----------|
| 0 | clock-select |
| 1–3 | electrical group |
| 4–7 | physical-layer group; offset 5 is the error-and-status register |
| 8–11 | error-management group |
| 12–13 | vendor group |
| 14–15 | undefined |

Top module: `ppd_reg_gate`

## Requirements
- R1: On reset release, port 0 is up and ports 1 and above are down exactly when their strap pin is high. Every port's speed output equals DEFAULT_SPEED. Every stored register reads zero.
- R2: A clock-select write (offset 0) whose bits [3:0] equal 0xC powers the port down. A clock-select write with any other value in bits [3:0] powers it up. The new level appears on port_up from the cycle after the write.
- R3: After reset release, strap pin levels have no effect. A port powered up by a write stays up for any pin level.
- R4: The clock-select speed field, bits [SPD_W+3:4], is taken from a write only if the port was down before that write. Otherwise the field and port_speed keep their value.
- R5: While a port is down, its physical-layer, error-management and vendor registers read zero. Writes to them are discarded, so the old contents return once the port is up.
- R6: While a port is down, its error-and-status register (offset 5) reads 0x00000001.
- R7: The electrical group and the clock-select register can be read and written whatever the power state. Clock-select bits [3:0] and the bits above the speed field read back as written.
- R8: While a port is up, every register at offsets 1 to 13 reads back the last value written to it.
- R9: Offsets 14 and 15, and addresses whose bits above the port number are not zero, read zero and ignore writes.
- R10: Read data appears on reg_rdata in the cycle after the read strobe and is zero in any cycle not preceded by a strobe. Gating uses the power state of the access cycle.
- R11: Port 0 reaches a new speed through a power-down write followed by a power-up write that carries the speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_addr | input | ADDR_W | word address |
| reg_wr | input | 1 | write strobe |
| reg_wdata | input | DATA_W | write data |
| reg_rd | input | 1 | read strobe |
| reg_rdata | output | DATA_W | read data, one cycle after reg_rd |
| strap_pd | input | NUM_PORTS-1 | power-down strap pins for ports 1 and up (bit 0 is port 1) |
| port_up | output | NUM_PORTS | per-port power-up level |
| port_speed | output | NUM_PORTS*SPD_W | per-port speed code, port p at bits [p*SPD_W +: SPD_W] |

## Verification
The assertions assume that the bus never asserts a read and a write in the same cycle. They also assume that no clock-select write arrives during the single boot cycle, because the gating and speed properties take that cycle's pin sampling as settled. The bench issues one access at a time with idle cycles between accesses, and it starts traffic only several cycles after reset release. Strap pins change only well after boot, so any port_up movement seen at that point must come from a register write.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    localparam int WIN_BITS = 4;
    localparam int SPD_LSB  = 4;

    localparam logic [WIN_BITS-1:0] OFF_CKSEL   = 4'd0;
    localparam logic [WIN_BITS-1:0] ELEC_LO     = 4'd1;
    localparam logic [WIN_BITS-1:0] ELEC_HI     = 4'd3;
    localparam logic [WIN_BITS-1:0] PHY_LO      = 4'd4;
    localparam logic [WIN_BITS-1:0] PHY_HI      = 4'd7;
    localparam logic [WIN_BITS-1:0] ERRSTAT_OFF = 4'd5;
    localparam logic [WIN_BITS-1:0] ERRM_LO     = 4'd8;
    localparam logic [WIN_BITS-1:0] ERRM_HI     = 4'd11;
    localparam logic [WIN_BITS-1:0] VEND_LO     = 4'd12;
    localparam logic [WIN_BITS-1:0] VEND_HI     = 4'd13;

    localparam logic [3:0] PD_CODE = 4'hC;

    typedef enum logic [2:0] {
        GRP_CKSEL,
        GRP_ELEC,
        GRP_PHY,
        GRP_ERRM,
        GRP_VEND,
        GRP_NONE
    } grp_e;

    typedef enum logic [1:0] {
        PWR_BOOT,
        PWR_STRAP_DOWN,
        PWR_REG_DOWN,
        PWR_UP
    } pwr_e;

    function automatic grp_e grp_of(input logic [WIN_BITS-1:0] off);
        grp_e g;
        if (off == OFF_CKSEL)                      g = GRP_CKSEL;
        else if (off >= ELEC_LO && off <= ELEC_HI) g = GRP_ELEC;
        else if (off >= PHY_LO && off <= PHY_HI)   g = GRP_PHY;
        else if (off >= ERRM_LO && off <= ERRM_HI) g = GRP_ERRM;
        else if (off >= VEND_LO && off <= VEND_HI) g = GRP_VEND;
        else                                       g = GRP_NONE;
        return g;
    endfunction

    function automatic logic grp_gated(input grp_e g);
        return (g == GRP_PHY) || (g == GRP_ERRM) || (g == GRP_VEND);
    endfunction

endpackage

// File: rtl/ppd_addr_decode.sv
module ppd_addr_decode
    import ppd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]                            addr,
    output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] port_idx,
    output logic [WIN_BITS-1:0]                          off,
    output grp_e                                         grp,
    output logic                                         hit
);

    localparam int PORT_BITS = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int USED_BITS = WIN_BITS + PORT_BITS;

    logic upper_ok;
    logic port_ok;

    assign off      = addr[WIN_BITS-1:0];
    assign port_idx = addr[WIN_BITS +: PORT_BITS];

    generate
        if (ADDR_W > USED_BITS) begin : g_upper
            assign upper_ok = (addr[ADDR_W-1:USED_BITS] == '0);
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign port_ok = ({1'b0, port_idx} < (PORT_BITS+1)'(NUM_PORTS));
    assign hit     = upper_ok && port_ok;
    assign grp     = hit ? grp_of(off) : GRP_NONE;

endmodule

// File: rtl/ppd_port_ctrl.sv
module ppd_port_ctrl
    import ppd_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          SPD_W     = 3,
    parameter bit          HAS_PIN   = 1'b1,
    parameter logic [SPD_W-1:0] DEF_SPEED = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pd,
    input  logic              cksel_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cksel_q,
    output logic              port_up,
    output logic [SPD_W-1:0]  speed
);

    localparam int HI_LSB = SPD_LSB + SPD_W;
    localparam int HI_W   = DATA_W - HI_LSB;

    pwr_e state_q, state_d;

    logic              pin_eff;
    logic              pd_req;
    logic [3:0]        nib_q;
    logic [HI_W-1:0]   hi_q;
    logic [SPD_W-1:0]  speed_q;

    assign pin_eff = HAS_PIN ? strap_pd : 1'b0;
    assign pd_req  = (wdata[3:0] == PD_CODE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_BOOT;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_BOOT: begin
                if (cksel_we)     state_d = pd_req ? PWR_REG_DOWN : PWR_UP;
                else if (pin_eff) state_d = PWR_STRAP_DOWN;
                else              state_d = PWR_UP;
            end
            PWR_STRAP_DOWN, PWR_REG_DOWN: begin
                if (cksel_we)     state_d = pd_req ? PWR_REG_DOWN : PWR_UP;
            end
            PWR_UP: begin
                if (cksel_we && pd_req) state_d = PWR_REG_DOWN;
            end
            default: state_d = PWR_BOOT;
        endcase
    end

    // Clock-select contents: the speed field moves only from a down state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_q   <= 4'h0;
            hi_q    <= '0;
            speed_q <= DEF_SPEED;
        end else if (cksel_we) begin
            nib_q <= wdata[3:0];
            hi_q  <= wdata[DATA_W-1:HI_LSB];
            if (state_q != PWR_UP) speed_q <= wdata[SPD_LSB +: SPD_W];
        end else if (state_q == PWR_BOOT) begin
            nib_q <= pin_eff ? PD_CODE : 4'h0;
        end
    end

    // Outputs.
    always_comb begin
        port_up = (state_q == PWR_UP);
        speed   = speed_q;
        cksel_q = {hi_q, speed_q, nib_q};
    end

endmodule

// File: rtl/ppd_port_regs.sv
module ppd_port_regs
    import ppd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [WIN_BITS-1:0] off,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                port_up,
    output logic [DATA_W-1:0]   rval
);

    localparam int NUM_OFFS = 2 ** WIN_BITS;

    logic [DATA_W-1:0] word_q [NUM_OFFS];
    grp_e              grp;
    logic              wr_ok;

    assign grp   = grp_of(off);
    assign wr_ok = we && ((grp == GRP_ELEC) || (grp_gated(grp) && port_up));

    generate
        for (genvar o = 0; o < NUM_OFFS; o++) begin : g_word
            localparam grp_e OG = grp_of(WIN_BITS'(o));
            if (OG == GRP_ELEC || OG == GRP_PHY || OG == GRP_ERRM || OG == GRP_VEND) begin : g_store
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                             word_q[o] <= '0;
                    else if (wr_ok && off == WIN_BITS'(o))  word_q[o] <= wdata;
                end
            end else begin : g_empty
                assign word_q[o] = '0;
            end
        end
    endgenerate

    always_comb begin
        rval = '0;
        if (grp == GRP_ELEC) begin
            rval = word_q[off];
        end else if (grp_gated(grp)) begin
            if (port_up)                   rval = word_q[off];
            else if (off == ERRSTAT_OFF)   rval = DATA_W'(1);
            else                           rval = '0;
        end
    end

endmodule

// File: rtl/ppd_reg_gate.sv
module ppd_reg_gate
    import ppd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SPD_W     = 3,
    parameter int DEF_SPEED = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [DATA_W-1:0]          reg_wdata,
    input  logic                       reg_rd,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_PORTS-2:0]       strap_pd,
    output logic [NUM_PORTS-1:0]       port_up,
    output logic [NUM_PORTS*SPD_W-1:0] port_speed
);

    localparam int PORT_BITS = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [PORT_BITS-1:0] port_idx;
    logic [WIN_BITS-1:0]  off;
    grp_e                 grp;
    logic                 hit;

    logic [DATA_W-1:0] port_rval [NUM_PORTS];
    logic [DATA_W-1:0] rd_sel;

    ppd_addr_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) dec_i (
        .addr     (reg_addr),
        .port_idx (port_idx),
        .off      (off),
        .grp      (grp),
        .hit      (hit)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic              sel;
            logic              pin;
            logic [DATA_W-1:0] cksel_q;
            logic [DATA_W-1:0] reg_rval;

            assign sel = hit && (port_idx == PORT_BITS'(p));

            if (p == 0) begin : g_nopin
                assign pin = 1'b0;
            end else begin : g_pin
                assign pin = strap_pd[p-1];
            end

            ppd_port_ctrl #(
                .DATA_W    (DATA_W),
                .SPD_W     (SPD_W),
                .HAS_PIN   (p != 0),
                .DEF_SPEED (SPD_W'(DEF_SPEED))
            ) ctrl_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .strap_pd (pin),
                .cksel_we (reg_wr && sel && (grp == GRP_CKSEL)),
                .wdata    (reg_wdata),
                .cksel_q  (cksel_q),
                .port_up  (port_up[p]),
                .speed    (port_speed[p*SPD_W +: SPD_W])
            );

            ppd_port_regs #(
                .DATA_W (DATA_W)
            ) regs_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (reg_wr && sel),
                .off     (off),
                .wdata   (reg_wdata),
                .port_up (port_up[p]),
                .rval    (reg_rval)
            );

            assign port_rval[p] = (grp == GRP_CKSEL) ? cksel_q : reg_rval;
        end
    endgenerate

    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit && port_idx == PORT_BITS'(p)) rd_sel = port_rval[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_sel;
        else             reg_rdata <= '0;
    end

endmodule

// File: rtl/ppd_reg_gate_chk.sv
module ppd_reg_gate_chk #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SPD_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [DATA_W-1:0]          reg_rdata,
    input logic [NUM_PORTS-1:0]       port_up,
    input logic [NUM_PORTS*SPD_W-1:0] port_speed
);

    localparam int STRIDE = 16;

    logic boot_done;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_done <= 1'b0;
        else        boot_done <= 1'b1;
    end

    // R10
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));

    // R9
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ((32'(reg_addr) >= NUM_PORTS*STRIDE) || (32'(reg_addr[3:0]) >= 14)))
        |=> (reg_rdata == '0));

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            localparam int BASE = p * STRIDE;

            // R4
            speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                port_up[p] |=> $stable(port_speed[p*SPD_W +: SPD_W]));

            // R6
            errstat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd && (32'(reg_addr) == BASE + 5) && !port_up[p])
                |=> (reg_rdata == DATA_W'(1)));

            // R5
            gated_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd && !port_up[p] && (32'(reg_addr) >= BASE + 4) &&
                 (32'(reg_addr) <= BASE + 13) && (32'(reg_addr) != BASE + 5))
                |=> (reg_rdata == '0));

            // R3
            pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (boot_done && !(reg_wr && (32'(reg_addr) == BASE)))
                |=> $stable(port_up[p]));
        end
    endgenerate

endmodule

bind ppd_reg_gate ppd_reg_gate_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SPD_W     (SPD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .port_up    (port_up),
    .port_speed (port_speed)
);

// File: tb/ppd_reg_gate_tb.sv
module ppd_reg_gate_tb_top;

    localparam int NP  = 4;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int SW  = 3;
    localparam int DEF = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic [NP-2:0] strap_pd = 3'b101;
    logic [NP-1:0] port_up;
    logic [NP*SW-1:0] port_speed;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_mem [NP][16];
    logic [DW-1:0] m_ck  [NP];
    logic          m_up  [NP];
    logic [SW-1:0] m_spd [NP];

    always #10 clk = ~clk;

    ppd_reg_gate #(
        .NUM_PORTS (NP), .ADDR_W (AW), .DATA_W (DW), .SPD_W (SW), .DEF_SPEED (DEF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rd (reg_rd), .reg_rdata (reg_rdata),
        .strap_pd (strap_pd), .port_up (port_up), .port_speed (port_speed)
    );

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        int p = a / 16;
        int o = a % 16;
        if (a >= NP*16 || o >= 14) return "R9";
        if (o <= 3)                return "R7";
        if (m_up[p])               return "R8";
        if (o == 5)                return "R6";
        return "R5";
    endfunction

    function automatic logic [DW-1:0] exp_read(input int a);
        int p = a / 16;
        int o = a % 16;
        if (a >= NP*16 || o >= 14) return '0;
        if (o == 0)                return m_ck[p];
        if (o <= 3)                return m_mem[p][o];
        if (m_up[p])               return m_mem[p][o];
        return (o == 5) ? 32'h1 : 32'h0;
    endfunction

    task automatic model_write(input int a, input logic [DW-1:0] d);
        int p = a / 16;
        int o = a % 16;
        if (a >= NP*16 || o >= 14) return;
        if (o == 0) begin
            if (!m_up[p]) m_spd[p] = d[6:4];
            m_up[p] = (d[3:0] != 4'hC);
            m_ck[p] = {d[31:7], m_spd[p], d[3:0]};
        end else if (o <= 3 || m_up[p]) begin
            m_mem[p][o] = d;
        end
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read_chk(input int a);
        @(negedge clk);
        reg_addr = AW'(a);
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        chk(reg_rdata, exp_read(a), tag_of(a));
    endtask

    task automatic out_chk(input string tag);
        for (int p = 0; p < NP; p++) begin
            chk(DW'(port_up[p]), DW'(m_up[p]), tag);
            chk(DW'(port_speed[p*SW +: SW]), DW'(m_spd[p]), tag);
        end
    endtask

    task automatic read_all();
        for (int a = 0; a < 256; a++) bus_read_chk(a);
    endtask

    task automatic write_sweep(input int round);
        for (int a = 0; a < 256; a++) begin
            if (a % 16 != 0) bus_write(a, {8'(a), 8'(round), 16'(a * 7 + 16'h5A00)});
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            for (int o = 0; o < 16; o++) m_mem[p][o] = '0;
            m_spd[p] = SW'(DEF);
            m_up[p]  = (p == 0) ? 1'b1 : !strap_pd[p-1];
            m_ck[p]  = {25'b0, SW'(DEF), (m_up[p] ? 4'h0 : 4'hC)};
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state: ports 0 and 2 up, 1 and 3 held by strap
        chk(DW'(port_up), DW'(4'b0101), "R1");
        out_chk("R1");
        // R3 pins change after boot: no effect
        strap_pd = 3'b010;
        repeat (5) @(negedge clk);
        out_chk("R3");
        read_all();
        write_sweep(1);
        read_all();
        // R2/R4 port 1 wakes with speed 5
        bus_write(16, 32'h0000_0050);
        repeat (2) @(negedge clk);
        out_chk("R2");
        // R4 speed change while up is ignored
        bus_write(16, 32'h0000_0023);
        repeat (2) @(negedge clk);
        out_chk("R4");
        // R2 port 2 sleeps
        bus_write(32, 32'hABCD_001C);
        repeat (2) @(negedge clk);
        out_chk("R2");
        // R11 port 0 speed change sequence
        bus_write(0, 32'h0000_0060);
        out_chk("R11");
        bus_write(0, 32'h0000_000C);
        out_chk("R11");
        bus_write(0, 32'h1200_0060);
        repeat (2) @(negedge clk);
        out_chk("R11");
        chk(DW'(port_speed[SW-1:0]), DW'(6), "R11");
        // R4 speed taken while down, port 3 stays down
        bus_write(48, 32'h0000_007C);
        repeat (2) @(negedge clk);
        out_chk("R4");
        // R3 pin toggling again
        strap_pd = 3'b111;
        repeat (4) @(negedge clk);
        out_chk("R3");
        read_all();
        write_sweep(2);
        read_all();
        // R10 timing: data only in the cycle after the strobe
        @(negedge clk);
        reg_addr = AW'(1);
        reg_rd   = 1'b1;
        #1;
        chk(reg_rdata, '0, "R10");
        @(negedge clk);
        reg_rd = 1'b0;
        chk(reg_rdata, exp_read(1), "R10");
        @(negedge clk);
        chk(reg_rdata, '0, "R10");
        // R10 gating follows state at access: sleep port 0 then read phy
        bus_write(0, 32'h0000_000C);
        bus_read_chk(4);
        bus_read_chk(5);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule